// File: doc/BRIEF.md
# Stream DMA Interrupt and Completion Counter

This block is the interrupt and completion bookkeeping for one channel of a stream DMA engine. The datapath sends it single-cycle event pulses: a transfer-complete pulse and six other error and condition pulses. The block collects them in an 8-bit sticky interrupt status register. Software clears a status bit by writing 1 to it.

A mask register gates the status bits onto one level-sensitive interrupt line. Software cannot write the mask directly. It changes the mask through two write-only registers: one unmasks the bits written as 1, the other masks them. The reset value of the mask depends on the direction of the channel, which is set at elaboration by a parameter.

The channel status word carries an 11-bit completion counter and a busy flag. The counter goes up once for each finished transfer. It goes down when software clears a done bit that is set. It can also be cleared directly, bit by bit, by writing 1. The register map (word address on a 3-bit port) is:

| Address | Register |
|---|---|
| 0 | channel status |
| 1 | interrupt status |
| 2 | interrupt enable |
| 3 | interrupt disable |
| 4 | mask |

Top module: `dma_irq_ctrl`

## Requirements
- R1: Interrupt status bit positions are: 7 FIFO overflow, 6 invalid register access, 5 FIFO threshold, 4 memory timeout, 3 stream timeout, 2 read error, 1 done, 0 memory done. `evt_i[k]` sets status bit k+2 on the following clock edge, and a set bit stays set until software clears it.
- R2: A write to address 1 clears each status bit whose data bit is 1 and leaves the others unchanged. Reads of address 1 return the status in bits 7:0 and zero in bits 31:8.
- R3: A write to address 2 clears the mask bits written as 1, and a write to address 3 sets them. Addresses 2 and 3 read as zero. Writes to the mask at address 4 are ignored, and address 4 reads the mask in bits 7:0.
- R4: `irq_o` is 1 exactly when some status bit is 1 while its mask bit is 0.
- R5: After reset the status is 0 and the completion count is 0. The mask is 0x7F when IS_DST=0 (source channel) and 0xFE when IS_DST=1 (destination channel).
- R6: A `done_i` pulse sets status bit 1 and increments the completion count by one. On a source channel (IS_DST=0) it also sets status bit 0.
- R7: A status write with data bit 1 set decrements the completion count by one only if status bit 1 was 1 before the write. Otherwise the count is unchanged.
- R8: Address 0 reads `busy_i` in bit 0, the completion count in bits 13:3, and zero elsewhere. A write to address 0 clears the count bits whose data bits 13:3 are 1. The count wraps modulo 2^11.
- R9: If a `done_i` pulse and a write that clears a set done bit arrive in the same cycle, the count keeps its value and status bit 1 stays 1.
- R10: If an event pulse and a write clearing the same status bit arrive in the same cycle, the bit ends up set.
- R11: Read data is combinational from the registers. A write becomes visible on the cycle after its clock edge, and any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Word address of the read |
| rd_data | output | 32 | Read data |
| evt_i | input | 6 | Event pulses for status bits 7:2 |
| done_i | input | 1 | Transfer-complete pulse |
| busy_i | input | 1 | Channel busy flag from the datapath |
| irq_o | output | 1 | Level-sensitive interrupt |

## Verification
Directed sequences look at the counter alone:
- repeated done pulses, to show that the count climbs;
- clearing a done bit that is set and one that is not, to separate the decrement condition from a plain clear;
- a done pulse in the same cycle as a done clear, where a wrong order of operations would move the count or drop the bit;
- an event that coincides with a clear of the same bit.

Mask and interrupt checks use enable and disable writes on a bit whose status is set, to see the line follow the mask. Direct writes to the mask address check that they have no effect.

A seeded random phase mixes writes to every address, including unused ones, with sparse event and done pulses and a changing busy flag. Its results are compared with a reference model kept in the bench. This phase finds interactions the directed cases miss, such as count wrap after an acknowledge at zero.

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter bit IS_DST = 1'b0,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [5:0]        evt_i,
  input  logic              done_i,
  input  logic              busy_i,
  output logic              irq_o
);
  localparam int CNT_LSB = 3;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ISR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IDIS = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(4);
  localparam logic [7:0] MASK_RST = IS_DST ? 8'hFE : 8'h7F;

  logic [7:0]       isr, mask;
  logic [CNT_W-1:0] cnt;

  wire wr_stat = wr_en && (wr_addr == A_STAT);
  wire wr_isr  = wr_en && (wr_addr == A_ISR);
  wire wr_ien  = wr_en && (wr_addr == A_IEN);
  wire wr_idis = wr_en && (wr_addr == A_IDIS);

  wire [7:0] ev      = {evt_i, done_i, done_i & ~IS_DST};
  wire [7:0] isr_clr = wr_isr ? wr_data[7:0] : 8'h00;
  wire       ack     = wr_isr && wr_data[1] && isr[1];
  wire [CNT_W-1:0] cnt_clr = wr_stat ? wr_data[CNT_LSB +: CNT_W] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr  <= 8'h00;
      mask <= MASK_RST;
      cnt  <= '0;
    end else begin
      isr <= (isr & ~isr_clr) | ev;
      cnt <= (cnt & ~cnt_clr) + CNT_W'(done_i) - CNT_W'(ack);
      if (wr_ien)       mask <= mask & ~wr_data[7:0];
      else if (wr_idis) mask <= mask | wr_data[7:0];
    end
  end

  assign irq_o = |(isr & ~mask);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_STAT: begin
        rd_data[0] = busy_i;
        rd_data[CNT_LSB +: CNT_W] = cnt;
      end
      A_ISR:  rd_data[7:0] = isr;
      A_MASK: rd_data[7:0] = mask;
      default: rd_data = '0;
    endcase
  end

  p_event_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((isr & $past(ev)) == $past(ev)));

  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_isr |=> ((isr & $past(wr_data[7:0] & ~ev)) == 8'h00));

  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_isr && ev == 8'h00) |=> $stable(isr));

  p_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> ((mask & $past(wr_data[7:0])) == 8'h00));

  p_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idis |=> ((mask & $past(wr_data[7:0])) == $past(wr_data[7:0])));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ien && !wr_idis) |=> $stable(mask));

  p_cnt_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !wr_stat && !ack) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_cnt_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !done_i) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && done_i) |=> ($stable(cnt) && isr[1]));
endmodule

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data, rd_data_dst;
  logic [5:0] evt_i = '0;
  logic done_i = 1'b0, busy_i = 1'b0, irq_o, irq_dst;

  int tests = 0, fails = 0;
  logic [7:0]  m_isr, m_mask;
  logic [10:0] m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_ctrl #(.IS_DST(1'b0)) dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_i(evt_i), .done_i(done_i), .busy_i(busy_i), .irq_o(irq_o));

  dma_irq_ctrl #(.IS_DST(1'b1)) dut_dst (.clk(clk), .rst_n(rst_n), .wr_en(1'b0),
    .wr_addr(3'd0), .wr_data(32'd0), .rd_addr(3'd4), .rd_data(rd_data_dst),
    .evt_i(6'd0), .done_i(1'b0), .busy_i(1'b0), .irq_o(irq_dst));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [2:0] a, logic b);
    case (a)
      3'd0: exp_rd = {18'd0, m_cnt, 2'b00, b};
      3'd1: exp_rd = {24'd0, m_isr};
      3'd4: exp_rd = {24'd0, m_mask};
      default: exp_rd = 32'd0;
    endcase
  endfunction

  task automatic drive(logic we, logic [2:0] a, logic [31:0] d, logic [5:0] ev,
                       logic dn, logic bsy, logic [2:0] ra);
    logic ack;
    logic [10:0] ccl;
    wr_en = we; wr_addr = a; wr_data = d; evt_i = ev; done_i = dn;
    busy_i = bsy; rd_addr = ra;
    ack = we && a == 3'd1 && d[1] && m_isr[1];
    ccl = (we && a == 3'd0) ? d[13:3] : 11'd0;
    m_cnt = (m_cnt & ~ccl) + 11'(dn) - 11'(ack);
    m_isr = (m_isr & ~((we && a == 3'd1) ? d[7:0] : 8'h00)) | {ev, dn, dn};
    if (we && a == 3'd2) m_mask = m_mask & ~d[7:0];
    else if (we && a == 3'd3) m_mask = m_mask | d[7:0];
  endtask

  task automatic step();
    string tag;
    @(negedge clk);
    case (rd_addr)
      3'd0: tag = "R8";
      3'd1: tag = "R2";
      3'd2, 3'd3, 3'd4: tag = "R3";
      default: tag = "R11";
    endcase
    chk(tag, rd_data, exp_rd(rd_addr, busy_i));
    chk("R4", {31'd0, irq_o}, {31'd0, |(m_isr & ~m_mask)});
  endtask

  task automatic cyc(logic we, logic [2:0] a, logic [31:0] d, logic [5:0] ev,
                     logic dn, logic bsy, logic [2:0] ra);
    drive(we, a, d, ev, dn, bsy, ra);
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_isr = 8'h00; m_mask = 8'h7F; m_cnt = 11'd0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state
    cyc(0, 0, 0, 0, 0, 0, 3'd0); chk("R5", rd_data, 32'd0);
    cyc(0, 0, 0, 0, 0, 0, 3'd4); chk("R5", rd_data, 32'h7F);
    chk("R5", rd_data_dst, 32'hFE);
    cyc(0, 0, 0, 0, 0, 0, 3'd1); chk("R1", rd_data, 32'd0);
    chk("R4", {31'd0, irq_o}, 32'd0);

    // R6 completion sets done and memory-done, counts up
    cyc(0, 0, 0, 0, 1, 0, 3'd1); chk("R6", rd_data, 32'h3);
    chk("R4", {31'd0, irq_o}, 32'd0);
    cyc(0, 0, 0, 0, 0, 0, 3'd0); chk("R6", rd_data, 32'h8);
    cyc(0, 0, 0, 0, 1, 0, 3'd0); chk("R6", rd_data, 32'h10);

    // R7 decrement only when done was set
    cyc(1, 1, 32'h2, 0, 0, 0, 3'd0); chk("R7", rd_data, 32'h8);
    cyc(1, 1, 32'h2, 0, 0, 0, 3'd0); chk("R7", rd_data, 32'h8);

    // R9 simultaneous completion and acknowledge
    cyc(0, 0, 0, 0, 1, 0, 3'd0); chk("R9", rd_data, 32'h10);
    cyc(1, 1, 32'h2, 0, 1, 0, 3'd0); chk("R9", rd_data, 32'h10);
    cyc(0, 0, 0, 0, 0, 0, 3'd1); chk("R9", rd_data, 32'h3);

    // R10 event wins over clear; overflow unmasked on source channel
    cyc(1, 1, 32'h80, 6'b100000, 0, 0, 3'd1); chk("R10", rd_data, 32'h83);
    chk("R4", {31'd0, irq_o}, 32'd1);

    // R3 enable / disable / direct mask write
    cyc(1, 3, 32'h80, 0, 0, 0, 3'd4); chk("R3", rd_data, 32'hFF);
    chk("R4", {31'd0, irq_o}, 32'd0);
    cyc(1, 2, 32'h82, 0, 0, 0, 3'd2); chk("R3", rd_data, 32'h0);
    chk("R4", {31'd0, irq_o}, 32'd1);
    cyc(0, 0, 0, 0, 0, 0, 3'd4); chk("R3", rd_data, 32'h7D);
    cyc(1, 4, 32'hFF, 0, 0, 0, 3'd4); chk("R3", rd_data, 32'h7D);

    // R8 busy flag and count clear
    cyc(0, 0, 0, 0, 0, 1, 3'd0); chk("R8", rd_data, 32'h11);
    cyc(1, 0, 32'h11, 0, 0, 0, 3'd0); chk("R8", rd_data, 32'h0);

    // R2 partial clear, upper bits read zero; R11 old value before the edge
    drive(1, 1, 32'hFFFF_FF7D, 0, 0, 0, 3'd1);
    #1 chk("R11", rd_data, 32'h83);
    step(); chk("R2", rd_data, 32'h82);
    cyc(0, 0, 0, 0, 0, 0, 3'd6); chk("R11", rd_data, 32'h0);

    // Random phase against the bench model
    for (int i = 0; i < 4000; i++) begin
      logic we, dn, bsy;
      logic [2:0] a, ra;
      logic [31:0] d;
      logic [5:0] ev;
      we  = ($urandom % 3) == 0;
      a   = 3'($urandom % 8);
      d   = $urandom;
      if (a == 3'd0 && ($urandom % 8) != 0) d = d & 32'h7;
      ev  = (($urandom % 4) == 0) ? 6'($urandom) : 6'd0;
      dn  = ($urandom % 3) == 0;
      bsy = 1'($urandom);
      ra  = 3'($urandom % 8);
      cyc(we, a, d, ev, dn, bsy, ra);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule